// File: doc/BRIEF.md
# PCI Bus Transaction Phase Monitor

This block sits passively on a 32-bit multiplexed PCI bus and drives nothing onto it. It samples the three active-low framing and handshake lines, the shared address/data lines and the shared command/byte-enable lines on every rising edge of the bus clock. When a transaction starts, the block captures the address and the bus command. It classifies the command and raises a flag if the code is reserved. It then follows the data phases and reports each completed transfer with its data word, its byte-enable mask and its byte offset from the captured address.

The outputs are registered and appear one clock after the sampled edge. The address report is a one-cycle strobe, and the captured address, command, class and reserved flag are held until the next address phase. Each transfer is reported by a one-cycle strobe with its own data, mask, offset, a last-phase marker and a null marker. Target-side handshake lines other than TRDY#, arbitration, dual address cycles and configuration decoding are outside the block.

Top module: `pci_txn_monitor`

## Requirements
- R1: After a synchronous active-low reset, `addr_valid` and `xfer_valid` are 0 and the monitor is idle, so the next low sample of `frame_n` is an address phase.
- R2: When idle and `frame_n` is sampled low, `addr_valid` is 1 for exactly one cycle after that edge. `addr` then holds the sampled `ad` and `cmd` holds the sampled `cbe_n`. While a transaction is in progress, a low `frame_n` never raises `addr_valid`.
- R3: `cmd_class` encodes the captured command as follows: 0 for 0000 (interrupt acknowledge), 1 for 0001 (special cycle), 2 for 0010/0011 (I/O), 3 for 0110/1100/1110 (memory reads), 4 for 0111/1111 (memory writes), 5 for 1010/1011 (configuration), and 7 for anything else.
- R4: `cmd_rsvd` is 1 exactly when the captured command is 0100, 0101, 1000, 1001 or 1101. It is first raised in the same cycle as `addr_valid`.
- R5: During a transaction, `xfer_valid` pulses one cycle after each edge on which `irdy_n` and `trdy_n` are both low. An edge with either of them high is a wait state and produces no pulse.
- R6: With each `xfer_valid` pulse, `xfer_data` and `xfer_be_n` equal the `ad` and `cbe_n` values sampled on the transfer edge. Bit 0 of `xfer_be_n` covers `ad[7:0]` and bit 3 covers `ad[31:24]`.
- R7: `xfer_offset` is 0 for the first transfer of a transaction and grows by 4 for each later transfer. Wait states do not advance it.
- R8: `xfer_last` is 1 on a transfer whose edge saw `frame_n` high. The monitor is idle after that transfer, or after any in-transaction edge on which `frame_n` and `irdy_n` are both high.
- R9: A transfer with mask 1111 is still reported, and `xfer_null` is 1 with it. `xfer_null` is 0 on every other transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Transaction framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| ad | input | 32 | Multiplexed address/data |
| cbe_n | input | 4 | Command in address phase, active-low byte enables in data phases |
| addr_valid | output | 1 | One-cycle strobe: an address phase was seen |
| addr | output | 32 | Captured address |
| cmd | output | 4 | Captured command code |
| cmd_class | output | 3 | Decoded command class |
| cmd_rsvd | output | 1 | Captured command is reserved |
| xfer_valid | output | 1 | One-cycle strobe: a data word moved |
| xfer_data | output | 32 | Data word of the transfer |
| xfer_be_n | output | 4 | Byte-enable mask of the transfer |
| xfer_offset | output | OFF_W | Byte offset from the captured address |
| xfer_last | output | 1 | Transfer was the final data phase |
| xfer_null | output | 1 | Transfer enabled no byte lanes |

## Verification
Two functions share the same edge: the final transfer and the end of the transaction. They meet when the initiator releases `frame_n` in the same cycle that both ready lines are low. The bench provokes this after wait states of both kinds and also on a single-phase transaction whose first data phase is its last. It judges the result by the transfer's `xfer_last` flag and by whether the next low `frame_n`, after one idle cycle, is reported as a new address phase. A null mask on that same final edge is also exercised, so the last and null markers are checked together.

// File: rtl/pci_txn_monitor.sv
module pci_txn_monitor #(
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             trdy_n,
  input  logic [31:0]      ad,
  input  logic [3:0]       cbe_n,
  output logic             addr_valid,
  output logic [31:0]      addr,
  output logic [3:0]       cmd,
  output logic [2:0]       cmd_class,
  output logic             cmd_rsvd,
  output logic             xfer_valid,
  output logic [31:0]      xfer_data,
  output logic [3:0]       xfer_be_n,
  output logic [OFF_W-1:0] xfer_offset,
  output logic             xfer_last,
  output logic             xfer_null
);

  localparam logic [2:0] CLS_RSVD = 3'd7;
  localparam logic [OFF_W-1:0] STEP = OFF_W'(4);

  logic             busy;
  logic [OFF_W-1:0] off_q;
  logic [2:0]       cls;

  wire aphase = !busy && !frame_n;
  wire xfer   = busy && !irdy_n && !trdy_n;

  always_comb begin
    case (cbe_n)
      4'b0000:                   cls = 3'd0;
      4'b0001:                   cls = 3'd1;
      4'b0010, 4'b0011:          cls = 3'd2;
      4'b0110, 4'b1100, 4'b1110: cls = 3'd3;
      4'b0111, 4'b1111:          cls = 3'd4;
      4'b1010, 4'b1011:          cls = 3'd5;
      default:                   cls = CLS_RSVD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      off_q       <= '0;
      addr_valid  <= 1'b0;
      addr        <= '0;
      cmd         <= '0;
      cmd_class   <= '0;
      cmd_rsvd    <= 1'b0;
      xfer_valid  <= 1'b0;
      xfer_data   <= '0;
      xfer_be_n   <= '0;
      xfer_offset <= '0;
      xfer_last   <= 1'b0;
    end else begin
      addr_valid <= aphase;
      xfer_valid <= xfer;
      if (aphase) begin
        busy      <= 1'b1;
        off_q     <= '0;
        addr      <= ad;
        cmd       <= cbe_n;
        cmd_class <= cls;
        cmd_rsvd  <= (cls == CLS_RSVD);
      end else if (busy) begin
        if (xfer) begin
          xfer_data   <= ad;
          xfer_be_n   <= cbe_n;
          xfer_offset <= off_q;
          xfer_last   <= frame_n;
          off_q       <= off_q + STEP;
        end
        if (frame_n && (irdy_n || xfer))
          busy <= 1'b0;
      end
    end
  end

  assign xfer_null = xfer_valid && (&xfer_be_n);

endmodule

// File: rtl/pci_txn_monitor_chk.sv
module pci_txn_monitor_chk #(
  parameter int OFF_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irdy_n,
  input logic             trdy_n,
  input logic             addr_valid,
  input logic             cmd_rsvd,
  input logic             xfer_valid,
  input logic [OFF_W-1:0] xfer_offset,
  input logic             xfer_last,
  input logic             xfer_null
);

  a_r2_addr_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> !addr_valid);

  a_r2_addr_not_with_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_valid && xfer_valid));

  a_r4_rsvd_rises_with_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_rsvd) |-> addr_valid);

  a_r5_xfer_needs_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> $past(!irdy_n && !trdy_n));

  a_r7_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_last) |=> (!xfer_valid || xfer_offset == $past(xfer_offset) + OFF_W'(4)));

  a_r8_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_last) |=> !xfer_valid);

  a_r9_null_only_on_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_null |-> xfer_valid);

endmodule

bind pci_txn_monitor pci_txn_monitor_chk #(.OFF_W(OFF_W)) chk (
  .clk(clk), .rst_n(rst_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
  .addr_valid(addr_valid), .cmd_rsvd(cmd_rsvd), .xfer_valid(xfer_valid),
  .xfer_offset(xfer_offset), .xfer_last(xfer_last), .xfer_null(xfer_null)
);

// File: tb/pci_txn_monitor_test.sv
module pci_txn_monitor_test;
  localparam int OFF_W = 12;

  logic clk = 0, rst_n = 0;
  logic frame_n = 1, irdy_n = 1, trdy_n = 1;
  logic [31:0] ad = '0;
  logic [3:0] cbe_n = '0;
  logic addr_valid, cmd_rsvd, xfer_valid, xfer_last, xfer_null;
  logic [31:0] addr, xfer_data;
  logic [3:0] cmd, xfer_be_n;
  logic [2:0] cmd_class;
  logic [OFF_W-1:0] xfer_offset;

  always #4 clk = ~clk;

  pci_txn_monitor #(.OFF_W(OFF_W)) uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .ad(ad), .cbe_n(cbe_n), .addr_valid(addr_valid), .addr(addr), .cmd(cmd),
    .cmd_class(cmd_class), .cmd_rsvd(cmd_rsvd), .xfer_valid(xfer_valid),
    .xfer_data(xfer_data), .xfer_be_n(xfer_be_n), .xfer_offset(xfer_offset),
    .xfer_last(xfer_last), .xfer_null(xfer_null)
  );

  typedef struct {
    bit          is_xfer;
    logic [31:0] word;
    logic [3:0]  code;
    logic [2:0]  cls;
    bit          rsvd;
    logic [OFF_W-1:0] off;
    bit          last;
    bit          nul;
  } item_t;

  item_t exp_q[$];
  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [OFF_W-1:0] exp_off;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] class_of(logic [3:0] c);
    if (c == 4'b0000) return 3'd0;
    if (c == 4'b0001) return 3'd1;
    if (c[3:1] == 3'b001) return 3'd2;
    if (c == 4'b0110 || c == 4'b1100 || c == 4'b1110) return 3'd3;
    if (c == 4'b0111 || c == 4'b1111) return 3'd4;
    if (c[3:1] == 3'b101) return 3'd5;
    return 3'd7;
  endfunction

  task automatic drive(logic f, logic i, logic t, logic [31:0] d, logic [3:0] c);
    @(negedge clk);
    frame_n = f; irdy_n = i; trdy_n = t; ad = d; cbe_n = c;
  endtask

  task automatic addr_phase(logic [31:0] a, logic [3:0] c);
    item_t it;
    drive(0, 1, 1, a, c);
    it = '{is_xfer: 0, word: a, code: c, cls: class_of(c),
           rsvd: (c == 4'b0100 || c == 4'b0101 || c == 4'b1000 || c == 4'b1001 || c == 4'b1101),
           off: '0, last: 0, nul: 0};
    exp_q.push_back(it);
    exp_off = '0;
  endtask

  task automatic data_phase(logic [31:0] d, logic [3:0] be, bit last, int waits);
    item_t it;
    for (int w = 0; w < waits; w++) begin
      if (last || w[0]) drive(last, 0, 1, 32'hDEAD_0000 + w, 4'b0101);
      else              drive(0, 1, 0, 32'hBEEF_0000 + w, 4'b1010);
    end
    drive(last, 0, 0, d, be);
    it = '{is_xfer: 1, word: d, code: be, cls: 0, rsvd: 0, off: exp_off,
           last: last, nul: (be == 4'b1111)};
    exp_q.push_back(it);
    exp_off = exp_off + OFF_W'(4);
    if (last) drive(1, 1, 1, 32'h0, 4'h0);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done && (addr_valid || xfer_valid)) begin
      item_t e;
      check(!(addr_valid && xfer_valid), "R2", "address and transfer together", {30'd0, addr_valid, xfer_valid}, 32'd0);
      if (exp_q.size() == 0) begin
        check(0, "R5", "unexpected event", {30'd0, addr_valid, xfer_valid}, 32'd0);
      end else begin
        e = exp_q.pop_front();
        if (!e.is_xfer) begin
          check(addr_valid, "R2", "address strobe", {31'd0, addr_valid}, 32'd1);
          check(addr == e.word, "R2", "addr", addr, e.word);
          check(cmd == e.code, "R2", "cmd", {28'd0, cmd}, {28'd0, e.code});
          check(cmd_class == e.cls, "R3", "cmd_class", {29'd0, cmd_class}, {29'd0, e.cls});
          check(cmd_rsvd == e.rsvd, "R4", "cmd_rsvd", {31'd0, cmd_rsvd}, {31'd0, e.rsvd});
        end else begin
          check(xfer_valid, "R5", "transfer strobe", {31'd0, xfer_valid}, 32'd1);
          check(xfer_data == e.word, "R6", "xfer_data", xfer_data, e.word);
          check(xfer_be_n == e.code, "R6", "xfer_be_n", {28'd0, xfer_be_n}, {28'd0, e.code});
          check(xfer_offset == e.off, "R7", "xfer_offset", 32'(xfer_offset), 32'(e.off));
          check(xfer_last == e.last, "R8", "xfer_last", {31'd0, xfer_last}, {31'd0, e.last});
          check(xfer_null == e.nul, "R9", "xfer_null", {31'd0, xfer_null}, {31'd0, e.nul});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(addr_valid == 0, "R1", "addr_valid in reset", {31'd0, addr_valid}, 32'd0);
    check(xfer_valid == 0, "R1", "xfer_valid in reset", {31'd0, xfer_valid}, 32'd0);
    rst_n = 1;
    drive(1, 1, 1, 0, 0);

    // R5 R7: burst write, wait states of both kinds, offsets 0,4,8
    addr_phase(32'h1000_0040, 4'b0111);
    data_phase(32'h1111_2222, 4'b0000, 0, 0);
    data_phase(32'h3333_4444, 4'b1100, 0, 3);
    data_phase(32'h5555_6666, 4'b0011, 1, 2);

    // R8: single-phase read, first data phase is last
    addr_phase(32'h2000_0000, 4'b0110);
    data_phase(32'hCAFE_F00D, 4'b0000, 1, 0);

    // R9: null transfers, mid and on the last edge
    addr_phase(32'h3000_0100, 4'b1110);
    data_phase(32'h0BAD_0BAD, 4'b1111, 0, 1);
    data_phase(32'h1234_5678, 4'b1110, 0, 0);
    data_phase(32'h8765_4321, 4'b1111, 1, 0);

    // R3 R4: every command code
    for (int c = 0; c < 16; c++) begin
      addr_phase(32'hA000_0000 + c * 16, c[3:0]);
      data_phase(32'h5A5A_0000 + c, 4'b0000, 1, c % 3);
    end

    // R8: return to idle on FRAME# and IRDY# high without a final transfer
    addr_phase(32'h4000_0000, 4'b0010);
    data_phase(32'h0000_00AA, 4'b1110, 0, 0);
    drive(1, 1, 1, 0, 0);
    drive(1, 1, 1, 0, 0);
    addr_phase(32'h4400_0000, 4'b0011);
    data_phase(32'h0000_00BB, 4'b0000, 1, 0);

    // R1: reset mid-transaction clears the busy state
    addr_phase(32'h5000_0000, 4'b0111);
    data_phase(32'h0000_0001, 4'b0000, 0, 0);
    drive(0, 1, 1, 0, 0);
    drive(0, 1, 1, 0, 0);
    @(negedge clk);
    rst_n = 0; frame_n = 0; irdy_n = 0; trdy_n = 0;
    @(negedge clk);
    check(xfer_valid == 0, "R1", "xfer_valid after reset", {31'd0, xfer_valid}, 32'd0);
    check(addr_valid == 0, "R1", "addr_valid after reset", {31'd0, addr_valid}, 32'd0);
    frame_n = 1; irdy_n = 1; trdy_n = 1;
    @(negedge clk);
    rst_n = 1;
    addr_phase(32'h5500_0000, 4'b1010);
    data_phase(32'h0000_0002, 4'b0000, 1, 0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5", "pending expected events", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule